// File: doc/BRIEF.md
# Operand Addressing Mode Unit

This unit resolves a single instruction operand according to an addressing mode code. For constant and register modes it returns the operand value itself; for every memory mode it returns the effective byte address that the load/store path should use. The autoincrement and autodecrement modes also produce an updated pointer value and a write-back enable for the register file.

Each request is a one-cycle `start` pulse that carries the mode, two register read values, a constant field and an access size. All modes except memory-indirect finish one cycle later with a one-cycle `done` pulse. Memory-indirect mode first reads a pointer word from memory through a simple request/valid read port, holds the request until the valid arrives, and then returns the word it read as the final operand address. Register file, ALU and instruction decode lie outside the unit.

Top module: `opnd_addr_unit`

## Requirements
- R1: While reset is held and on the first cycle after it, `done`, `wb_en` and `mem_req` are low.
- R2: Mode 0 (immediate) returns `cnst` with `res_is_addr`=0; modes 11 to 15 are reserved and return 0 with `res_is_addr`=0. For every mode except 10, `done` is high in the cycle after the accepted `start`.
- R3: Mode 1 (register) returns `reg_a` with `res_is_addr`=0; mode 2 (direct) returns `cnst` with `res_is_addr`=1.
- R4: Mode 3 (register indirect) returns `reg_a` as address; mode 8 (displacement) returns `cnst + reg_a` as address.
- R5: The access size `size_code` maps 0 to 1 byte, 1 to 2 bytes, and 2 or 3 to 4 bytes. Mode 4 (post-increment) returns `reg_a` as address and writes back `reg_a + size`; mode 5 (pre-increment) returns and writes back `reg_a + size`.
- R6: Mode 6 (post-decrement) returns `reg_a` as address and writes back `reg_a - size`; mode 7 (pre-decrement) returns and writes back `reg_a - size`.
- R7: Mode 9 (indexed) returns `reg_a + reg_b` as address, or `reg_a + idx_reg` when parameter `IMPLICIT_IDX` is 1.
- R8: Mode 10 (memory indirect) raises `mem_req` from the cycle after `start`, with `mem_addr` = `reg_a` held steady until `mem_rvalid`; in the cycle after `mem_rvalid`, `done` is high and `res_val` equals the `mem_rdata` that came with it, with `res_is_addr`=1.
- R9: `wb_en` is high only together with `done`, and only for modes 4 to 7.
- R10: `done` lasts exactly one cycle, and a `start` while a memory-indirect request is pending is ignored.
- R11: All address sums and differences wrap modulo 2^AW with no flag.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| start | input | 1 | Request pulse, accepted when idle |
| mode | input | 4 | Addressing mode code |
| size_code | input | 2 | Access size code |
| reg_a | input | AW | Base/pointer register value |
| reg_b | input | AW | Second register value (indexed mode) |
| idx_reg | input | AW | Implicit index register value |
| cnst | input | AW | Constant field of the instruction |
| mem_req | output | 1 | Pointer read request |
| mem_addr | output | AW | Pointer read address |
| mem_rdata | input | AW | Pointer read data |
| mem_rvalid | input | 1 | Pointer read data valid |
| res_val | output | AW | Operand value or effective address |
| res_is_addr | output | 1 | res_val is an address |
| wb_data | output | AW | Updated pointer value |
| wb_en | output | 1 | Pointer write-back enable |
| done | output | 1 | Result valid pulse |

## Verification
The assertions assume `mem_rvalid` is only driven while `mem_req` is high and that `mem_rdata` is meaningful only in that cycle; the stimulus raises valid exactly once per pointer fetch after a chosen wait. They also take `start` to be a single-cycle pulse; the bench drops it on the next falling edge, and the one extra pulse it sends on purpose lands while a pointer fetch is pending. Sweeps cover every mode code, all size codes and base values at both ends of the address range so the wrap cases are reached.

// File: rtl/opnd_addr_unit.sv
module opnd_addr_unit #(
  parameter int AW = 16,
  parameter bit IMPLICIT_IDX = 1'b0
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          start,
  input  logic [3:0]    mode,
  input  logic [1:0]    size_code,
  input  logic [AW-1:0] reg_a,
  input  logic [AW-1:0] reg_b,
  input  logic [AW-1:0] idx_reg,
  input  logic [AW-1:0] cnst,
  output logic          mem_req,
  output logic [AW-1:0] mem_addr,
  input  logic [AW-1:0] mem_rdata,
  input  logic          mem_rvalid,
  output logic [AW-1:0] res_val,
  output logic          res_is_addr,
  output logic [AW-1:0] wb_data,
  output logic          wb_en,
  output logic          done
);
  localparam logic [3:0] M_IMM = 4'd0, M_REG = 4'd1, M_DIR = 4'd2, M_RIND = 4'd3;
  localparam logic [3:0] M_POSTINC = 4'd4, M_PREINC = 4'd5, M_POSTDEC = 4'd6, M_PREDEC = 4'd7;
  localparam logic [3:0] M_DISP = 4'd8, M_IDX = 4'd9, M_MIND = 4'd10;

  typedef enum logic [1:0] {S_IDLE, S_PTR, S_DONE} st_t;
  st_t state;

  logic [AW-1:0] res_q, wb_q;
  logic          addr_q, wben_q;
  logic [AW-1:0] n_res, n_wb;
  logic          n_addr, n_wben;

  logic [AW-1:0] step, inc_v, dec_v, second;
  assign step   = (size_code == 2'd0) ? AW'(1) : (size_code == 2'd1) ? AW'(2) : AW'(4);
  assign inc_v  = reg_a + step;
  assign dec_v  = reg_a - step;
  assign second = IMPLICIT_IDX ? idx_reg : reg_b;

  always_comb begin
    n_res  = '0;
    n_wb   = '0;
    n_addr = 1'b1;
    n_wben = 1'b0;
    case (mode)
      M_IMM:     begin n_res = cnst;  n_addr = 1'b0; end
      M_REG:     begin n_res = reg_a; n_addr = 1'b0; end
      M_DIR:     n_res = cnst;
      M_RIND:    n_res = reg_a;
      M_POSTINC: begin n_res = reg_a; n_wb = inc_v; n_wben = 1'b1; end
      M_PREINC:  begin n_res = inc_v; n_wb = inc_v; n_wben = 1'b1; end
      M_POSTDEC: begin n_res = reg_a; n_wb = dec_v; n_wben = 1'b1; end
      M_PREDEC:  begin n_res = dec_v; n_wb = dec_v; n_wben = 1'b1; end
      M_DISP:    n_res = cnst + reg_a;
      M_IDX:     n_res = reg_a + second;
      M_MIND:    n_res = reg_a;
      default:   n_addr = 1'b0;
    endcase
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      state  <= S_IDLE;
      res_q  <= '0;
      wb_q   <= '0;
      addr_q <= 1'b0;
      wben_q <= 1'b0;
    end else begin
      case (state)
        S_IDLE: if (start) begin
          res_q  <= n_res;
          wb_q   <= n_wb;
          addr_q <= n_addr;
          wben_q <= n_wben;
          state  <= (mode == M_MIND) ? S_PTR : S_DONE;
        end
        S_PTR: if (mem_rvalid) begin
          res_q <= mem_rdata;
          state <= S_DONE;
        end
        default: state <= S_IDLE;
      endcase
    end
  end

  assign done        = (state == S_DONE);
  assign mem_req     = (state == S_PTR);
  assign mem_addr    = res_q;
  assign res_val     = res_q;
  assign res_is_addr = addr_q;
  assign wb_data     = wb_q;
  assign wb_en       = done & wben_q;

  // R10
  done_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n) done |=> !done);
  // R9
  wb_in_done_chk: assert property (@(posedge clk) disable iff (!rst_n) wb_en |-> done);
  // R9
  wb_mode_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (state == S_IDLE && start && (mode < M_POSTINC || mode > M_PREDEC)) |=> !wb_en);
  // R8
  ptr_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (mem_req && !mem_rvalid) |=> (mem_req && $stable(mem_addr)));
  // R8
  ptr_load_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (mem_req && mem_rvalid) |=> (done && res_is_addr && res_val == $past(mem_rdata)));
  // R2
  one_cycle_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (state == S_IDLE && start && mode != M_MIND) |=> done);
endmodule

// File: tb/opnd_addr_unit_tb_top.sv
`timescale 1ns/1ps
module opnd_addr_unit_tb_top;
  localparam int AW = 8;
  logic clk = 1'b0;
  always #2.5 clk = ~clk;

  logic rst_n, start, mem_rvalid;
  logic [3:0] mode;
  logic [1:0] size_code;
  logic [AW-1:0] reg_a, reg_b, idx_reg, cnst, mem_rdata;
  logic mem_req, res_is_addr, wb_en, done;
  logic [AW-1:0] mem_addr, res_val, wb_data;
  logic x_req, x_isaddr, x_wben, x_done;
  logic [AW-1:0] x_addr, x_res, x_wb;
  int checks = 0, errors = 0;

  opnd_addr_unit #(.AW(AW), .IMPLICIT_IDX(1'b0)) dut_i (
    .clk, .rst_n, .start, .mode, .size_code, .reg_a, .reg_b, .idx_reg, .cnst,
    .mem_req, .mem_addr, .mem_rdata, .mem_rvalid, .res_val, .res_is_addr,
    .wb_data, .wb_en, .done);

  opnd_addr_unit #(.AW(AW), .IMPLICIT_IDX(1'b1)) dut_x (
    .clk, .rst_n, .start, .mode, .size_code, .reg_a, .reg_b, .idx_reg, .cnst,
    .mem_req(x_req), .mem_addr(x_addr), .mem_rdata, .mem_rvalid, .res_val(x_res),
    .res_is_addr(x_isaddr), .wb_data(x_wb), .wb_en(x_wben), .done(x_done));

  task automatic chk(input bit ok, input string req, input string what, input int act, input int expv);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s %s actual=%0h expected=%0h", req, what, act, expv);
    end
  endtask

  function automatic string tag(input int m);
    case (m)
      0: return "R2"; 1, 2: return "R3"; 3, 8: return "R4"; 4, 5: return "R5";
      6, 7: return "R6"; 9: return "R7"; 10: return "R8"; default: return "R2";
    endcase
  endfunction

  task automatic run_one(input int m, input int sz, input logic [AW-1:0] a, input logic [AW-1:0] b,
                         input logic [AW-1:0] c, input logic [AW-1:0] ix, input int waits);
    logic [AW-1:0] st, er, ew, rd;
    bit ea, ewe;
    st = (sz == 0) ? AW'(1) : (sz == 1) ? AW'(2) : AW'(4);
    er = '0; ew = '0; ea = 1'b1; ewe = 1'b0;
    case (m)
      0: begin er = c; ea = 1'b0; end
      1: begin er = a; ea = 1'b0; end
      2: er = c;
      3: er = a;
      4: begin er = a; ew = a + st; ewe = 1'b1; end
      5: begin er = a + st; ew = a + st; ewe = 1'b1; end
      6: begin er = a; ew = a - st; ewe = 1'b1; end
      7: begin er = a - st; ew = a - st; ewe = 1'b1; end
      8: er = c + a;
      9: er = a + b;
      10: er = c ^ 8'h5A;
      default: ea = 1'b0;
    endcase
    @(negedge clk);
    mode = 4'(m); size_code = 2'(sz); reg_a = a; reg_b = b; cnst = c; idx_reg = ix; start = 1'b1;
    if (m == 10) begin
      @(negedge clk);
      start = 1'b0;
      chk(mem_req && !done, "R8", "mem_req raised", int'(mem_req), 1);
      chk(mem_addr == a, "R8", "pointer address", int'(mem_addr), int'(a));
      for (int w = 0; w < waits; w++) begin
        if (w == 0) begin start = 1'b1; mode = 4'd0; end
        @(negedge clk);
        start = 1'b0;
        chk(mem_req && !done, "R10", "start ignored while fetching", int'(done), 0);
        chk(mem_addr == a, "R8", "pointer address held", int'(mem_addr), int'(a));
      end
      rd = c ^ 8'h5A;
      mem_rdata = rd; mem_rvalid = 1'b1;
      @(negedge clk);
      mem_rvalid = 1'b0; mem_rdata = '0;
      chk(done, "R8", "done after valid", int'(done), 1);
      chk(res_val == er && res_is_addr, "R8", "final address", int'(res_val), int'(er));
      chk(!wb_en, "R9", "no write-back", int'(wb_en), 0);
    end else begin
      @(negedge clk);
      start = 1'b0;
      chk(done, tag(m), "done one cycle after start", int'(done), 1);
      chk(res_val == er, tag(m), $sformatf("result mode %0d size %0d", m, sz), int'(res_val), int'(er));
      chk(res_is_addr == ea, tag(m), "res_is_addr", int'(res_is_addr), int'(ea));
      chk(wb_en == ewe, "R9", $sformatf("wb_en mode %0d", m), int'(wb_en), int'(ewe));
      if (ewe) chk(wb_data == ew, tag(m), "write-back value (R11 wrap)", int'(wb_data), int'(ew));
      if (m == 9) chk(x_res == AW'(a + ix), "R7", "implicit index sum", int'(x_res), int'(AW'(a + ix)));
    end
    @(negedge clk);
    chk(!done, "R10", "done single pulse", int'(done), 0);
  endtask

  initial begin
    #400000;
    errors++;
    $display("FAIL watchdog expired actual=%0d expected=%0d", checks, 0);
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    logic [AW-1:0] bases [5];
    bases = '{8'h00, 8'h01, 8'h7F, 8'hFE, 8'hFF};
    rst_n = 1'b0; start = 1'b0; mode = '0; size_code = '0; reg_a = '0; reg_b = '0;
    idx_reg = '0; cnst = '0; mem_rdata = '0; mem_rvalid = 1'b0;
    repeat (3) @(negedge clk);
    chk(!done && !wb_en && !mem_req, "R1", "outputs low in reset", int'({done, wb_en, mem_req}), 0);
    rst_n = 1'b1;
    @(negedge clk);
    chk(!done && !wb_en && !mem_req, "R1", "outputs low after reset", int'({done, wb_en, mem_req}), 0);
    for (int m = 0; m < 16; m++)
      for (int sz = 0; sz < 4; sz++)
        for (int k = 0; k < 5; k++)
          run_one(m, sz, bases[k], bases[(k + 2) % 5] + 8'h03, 8'hC0 + 8'(k * 17 + sz),
                  8'h80 + 8'(k), (m == 10) ? (k + sz) % 4 : 0);
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule